// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Streaming and Settled Modes

This block turns the one-bit output of a sigma-delta modulator into signed multi-bit samples. Each modulator sample is accepted on a cycle where the sample enable is high. A bit of one counts as +1 and a bit of zero counts as -1. The samples pass through three cascaded integrators running at the modulator rate. At the end of every 120 accepted samples, the value is handed to three cascaded differentiators running at the decimated rate. The response is that of three cascaded 120-tap boxcars, so the steady-state gain is 120^3.

There are two continuous modes.
- **Streaming mode** (`fast_mode` high) reports a result at the end of every 120-sample period once the filter has settled. An input step therefore takes three results to show fully.
- **Settled mode** (`fast_mode` low) clears the whole filter after each report. Every result it reports is built only from the 360 fresh samples that follow a clear, so it arrives at one third of the streaming rate.

Holding `run` low, a synchronous reset, or a change of mode each restarts the filter from a cleared state. After any restart, no result is flagged until three full periods have passed.

Top module: `sinc3_decim`

## Requirements
- R1: With every accepted bit equal to 1 (mapped to +1), a settled result equals +1728000 (120^3), and no flagged result ever lies outside ±1728000.
- R2: With every accepted bit equal to 0 (mapped to -1), a settled result equals -1728000.
- R3: Every flagged result equals the sum over j = 0..357 of h[j]·x[n-1-j]. Here n is the number of samples accepted since the last restart, x is the ±1 sample sequence taken as zero before the restart, and h is the convolution of three 120-long all-ones sequences.
- R4: With `fast_mode` high and the filter settled, exactly one result is flagged at the end of every 120 accepted samples, with no gaps.
- R5: With `fast_mode` low, exactly one result is flagged per 360 accepted samples, and the filter is cleared after each one, so consecutive results share no samples.
- R6: After a reset, a low `run`, or a change of `fast_mode`, no result is flagged before the 360th accepted sample, and the first flag belongs to exactly that sample.
- R7: `result_vld` is high for exactly one clock cycle. It rises in the cycle after the clock edge that accepts the sample closing a period. A synchronous reset drives `result` to 0 and `result_vld` low.
- R8: `result` keeps its value in every cycle where `result_vld` is low.
- R9: While `run` is low, enabled samples are discarded, nothing is flagged, and the filter stays cleared. Once `run` is high again, the first flagged result depends only on samples accepted after that point.
- R10: `bit_in` has no effect in cycles where `mod_en` is low.
- R11: In streaming mode, a step from all-zero to all-one input at a period boundary gives two intermediate results strictly between -1728000 and +1728000. The third result after the step is +1728000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| mod_en | input | 1 | Modulator sample enable, one cycle per bitstream sample |
| bit_in | input | 1 | Modulator bitstream bit (1 = +1, 0 = -1) |
| run | input | 1 | Continuous conversion enable; low holds the filter cleared |
| fast_mode | input | 1 | 1 = stream every period, 0 = flush and report settled samples |
| result | output | ACC_W (22) | Signed filter output, two's complement |
| result_vld | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with its defaults: ORDER = 3, DECIM = 120 and ACC_W = 22.

At these values the full-scale output of ±1728000 sits close to the 22-bit limit of ±2097151. The integrators wrap many times over a long run. Because of this, the reference comparisons also exercise the modular-arithmetic recovery in the differentiators and the exact sizing of the datapath.

With a 120-sample period, the bench can reach several periods in each mode, a mode change and a `run` gap within a short run. It also places the 360-sample settling edge at a cycle it can pin exactly.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   // Minimum register width for a cascade of 'order' stages decimating by 'decim'
   function automatic int cic_acc_width(int order, int decim);
      return order * $clog2(decim) + 1;
   endfunction

   // DC gain of the cascade: decim raised to the power of order
   function automatic longint cic_gain(int order, int decim);
      longint g;
      g = 1;
      for (int k = 0; k < order; k++) begin
         g = g * decim;
      end
      return g;
   endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
   parameter int ORDER = 3,
   parameter int DECIM = 120
) (
   input  logic clk,
   input  logic srst,
   input  logic run,
   input  logic fast_mode,
   input  logic mod_en,
   output logic smp,
   output logic dump,
   output logic emit,
   output logic flush
);
   localparam int CNT_W = $clog2(DECIM);
   localparam int PER_W = $clog2(ORDER + 1);

   logic [CNT_W-1:0] slot_q;
   logic [PER_W-1:0] per_q;
   logic             fm_q;
   logic             mode_chg;
   logic             last_slot;
   logic             settled;

   assign mode_chg  = (fast_mode != fm_q);
   assign smp       = run & mod_en & ~mode_chg & ~srst;
   assign last_slot = (slot_q == CNT_W'(DECIM - 1));
   assign settled   = (per_q == PER_W'(ORDER - 1));
   assign dump      = smp & last_slot;
   assign emit      = dump & settled;
   assign flush     = srst | ~run | mode_chg | (emit & ~fast_mode);

   always_ff @(posedge clk) begin
      fm_q <= fast_mode;
   end

   always_ff @(posedge clk) begin
      if (flush) begin
         slot_q <= '0;
         per_q  <= '0;
      end else if (smp) begin
         slot_q <= last_slot ? '0 : slot_q + 1'b1;
         if (last_slot && !settled) begin
            per_q <= per_q + 1'b1;
         end
      end
   end

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (srst)
      slot_q < CNT_W'(DECIM)); // R4
   AST_PER_RANGE: assert property (@(posedge clk) disable iff (srst)
      per_q < PER_W'(ORDER)); // R6
   AST_NO_SAMPLE_IDLE: assert property (@(posedge clk) disable iff (srst)
      !mod_en |-> !dump); // R10

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int ORDER = 3,
   parameter int ACC_W = 22
) (
   input  logic                    clk,
   input  logic                    flush,
   input  logic                    smp,
   input  logic                    bit_in,
   output logic signed [ACC_W-1:0] sum_nxt
);
   localparam logic signed [ACC_W-1:0] PLUS_ONE  = {{(ACC_W-1){1'b0}}, 1'b1};
   localparam logic signed [ACC_W-1:0] MINUS_ONE = '1;

   logic signed [ACC_W-1:0] acc_q [ORDER];
   logic signed [ACC_W-1:0] nxt   [ORDER+1];

   assign nxt[0] = bit_in ? PLUS_ONE : MINUS_ONE;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      assign nxt[k+1] = acc_q[k] + nxt[k];
      always_ff @(posedge clk) begin
         if (flush) begin
            acc_q[k] <= '0;
         end else if (smp) begin
            acc_q[k] <= nxt[k+1];
         end
      end
   end

   assign sum_nxt = nxt[ORDER];

   AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (flush)
      !$past(smp) && !$past(flush) |-> $stable(acc_q[0])); // R10

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int ORDER = 3,
   parameter int ACC_W = 22
) (
   input  logic                    clk,
   input  logic                    flush,
   input  logic                    dump,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [ACC_W-1:0] dout
);
   logic signed [ACC_W-1:0] dly_q [ORDER];
   logic signed [ACC_W-1:0] dif   [ORDER+1];

   assign dif[0] = din;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      assign dif[k+1] = dif[k] - dly_q[k];
      always_ff @(posedge clk) begin
         if (flush) begin
            dly_q[k] <= '0;
         end else if (dump) begin
            dly_q[k] <= dif[k];
         end
      end
   end

   assign dout = dif[ORDER];

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
   parameter int ORDER = 3,
   parameter int DECIM = 120,
   parameter int ACC_W = 22
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             mod_en,
   input  logic             bit_in,
   input  logic             run,
   input  logic             fast_mode,
   output logic [ACC_W-1:0] result,
   output logic             result_vld
);
   import sinc3_pkg::*;

   localparam longint GAIN   = cic_gain(ORDER, DECIM);
   localparam int     SETTLE = ORDER * DECIM;
   localparam int     CHK_W  = $clog2(SETTLE + 1);

   if (ORDER < 1) begin : g_bad_order
      $error("sinc3_decim: ORDER must be at least 1");
   end
   if (DECIM < 2) begin : g_bad_decim
      $error("sinc3_decim: DECIM must be at least 2");
   end
   if (ACC_W < cic_acc_width(ORDER, DECIM)) begin : g_bad_width
      $error("sinc3_decim: ACC_W too narrow for ORDER and DECIM");
   end

   logic                    smp;
   logic                    dump;
   logic                    emit;
   logic                    flush;
   logic signed [ACC_W-1:0] integ_out;
   logic signed [ACC_W-1:0] comb_out;

   sinc3_ctrl #(.ORDER(ORDER), .DECIM(DECIM)) ctrl_i (
      .clk       (clk),
      .srst      (srst),
      .run       (run),
      .fast_mode (fast_mode),
      .mod_en    (mod_en),
      .smp       (smp),
      .dump      (dump),
      .emit      (emit),
      .flush     (flush)
   );

   sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) integ_i (
      .clk     (clk),
      .flush   (flush),
      .smp     (smp),
      .bit_in  (bit_in),
      .sum_nxt (integ_out)
   );

   sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) comb_i (
      .clk   (clk),
      .flush (flush),
      .dump  (dump),
      .din   (integ_out),
      .dout  (comb_out)
   );

   always_ff @(posedge clk) begin
      if (srst) begin
         result     <= '0;
         result_vld <= 1'b0;
      end else begin
         result_vld <= emit;
         if (emit) begin
            result <= comb_out;
         end
      end
   end

   // Independent count of accepted samples since the last clear
   logic [CHK_W-1:0] chk_q;
   always_ff @(posedge clk) begin
      if (flush) begin
         chk_q <= '0;
      end else if (smp && chk_q != CHK_W'(SETTLE)) begin
         chk_q <= chk_q + 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (srst)
      result_vld |-> (longint'($signed(result)) <= GAIN) && (longint'($signed(result)) >= -GAIN)); // R1
   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (srst)
      result_vld |=> !result_vld); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (srst)
      !result_vld |-> $stable(result)); // R8
   AST_SETTLED_WINDOW: assert property (@(posedge clk) disable iff (srst)
      result_vld |-> $past(chk_q) >= CHK_W'(SETTLE - 1)); // R6
   AST_RUN_IDLE: assert property (@(posedge clk) disable iff (srst)
      $past(!run) |-> !result_vld); // R9

endmodule

// File: tb/sinc3_decim_tb_top.sv
`timescale 1ns/1ps
module sinc3_decim_tb_top;
   localparam int ORDER = 3;
   localparam int DECIM = 120;
   localparam int ACC_W = 22;
   localparam int TAPS  = ORDER * (DECIM - 1) + 1;
   localparam int FULL  = DECIM * DECIM * DECIM;

   logic             clk = 1'b0;
   logic             srst = 1'b1;
   logic             mod_en = 1'b0;
   logic             bit_in = 1'b0;
   logic             run = 1'b0;
   logic             fast_mode = 1'b1;
   logic [ACC_W-1:0] result;
   logic             result_vld;

   always #2 clk = ~clk;

   sinc3_decim #(.ORDER(ORDER), .DECIM(DECIM), .ACC_W(ACC_W)) dut_i (
      .clk        (clk),
      .srst       (srst),
      .mod_en     (mod_en),
      .bit_in     (bit_in),
      .run        (run),
      .fast_mode  (fast_mode),
      .result     (result),
      .result_vld (result_vld)
   );

   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   int    h [TAPS];
   int    t2 [2*DECIM-1];
   int    hist [512];
   int    nsamp = 0;
   bit    fast_m = 1'b1;
   string seg_tag = "R3";
   int    exp_val_q [$];
   int    exp_cyc_q [$];
   string exp_tag_q [$];
   int    got_vals [$];
   int    hold_err = 0;
   int    last_res = 0;
   bit    prev_vld = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, int act, int expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic void build_taps();
      for (int k = 0; k < 2*DECIM-1; k++) t2[k] = 0;
      for (int a = 0; a < DECIM; a++)
         for (int b = 0; b < DECIM; b++) t2[a+b]++;
      for (int j = 0; j < TAPS; j++) begin
         h[j] = 0;
         for (int c = 0; c < DECIM; c++)
            if (j - c >= 0 && j - c < 2*DECIM-1) h[j] += t2[j-c];
      end
   endfunction

   function automatic int ref_out(int n);
      int y;
      y = 0;
      for (int j = 0; j < TAPS; j++)
         if (n - 1 - j >= 0) y += h[j] * hist[(n-1-j) % 512];
      return y;
   endfunction

   // Driver: one accepted sample, expected items go to the scoreboard
   task automatic put_sample(bit b);
      int per;
      @(negedge clk);
      mod_en = 1'b1;
      bit_in = b;
      hist[nsamp % 512] = b ? 1 : -1;
      nsamp++;
      if (nsamp % DECIM == 0) begin
         per = nsamp / DECIM;
         if (fast_m ? (per >= ORDER) : (per == ORDER)) begin
            exp_val_q.push_back(ref_out(nsamp));
            exp_cyc_q.push_back(cyc + 1);
            exp_tag_q.push_back(seg_tag);
            if (!fast_m) nsamp = 0;
         end
      end
      @(negedge clk);
      mod_en = 1'b0;
      bit_in = ~b;
      repeat ($urandom_range(0, 2)) begin
         @(negedge clk);
         bit_in = $urandom_range(0, 1);   // R10: idle-cycle noise
      end
   endtask

   task automatic set_mode(bit f);
      @(negedge clk);
      fast_mode = f;
      fast_m = f;
      nsamp = 0;
   endtask

   task automatic drain(string tag);
      repeat (6) @(negedge clk);
      check({tag, " pending results"}, exp_val_q.size(), 0);
   endtask

   // Monitor
   always @(negedge clk) begin
      if (!srst) begin
         if (result_vld) begin
            if (prev_vld) check("R7 strobe width", 1, 0);
            got_vals.push_back($signed(result));
            if (exp_val_q.size() == 0) begin
               check("R5 R6 unexpected strobe", 1, 0);
            end else begin
               check(exp_tag_q[0], $signed(result), exp_val_q[0]);
               check("R7 strobe cycle", cyc, exp_cyc_q[0]);
               void'(exp_val_q.pop_front());
               void'(exp_cyc_q.pop_front());
               void'(exp_tag_q.pop_front());
            end
            last_res = $signed(result);
         end else if ($signed(result) != last_res) begin
            hold_err++;
         end
         prev_vld = result_vld;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      build_taps();
      repeat (5) @(negedge clk);
      srst = 1'b0;
      @(negedge clk);
      check("R7 reset result", int'(result), 0);
      check("R7 reset strobe", int'(result_vld), 0);
      run = 1'b1;
      nsamp = 0;

      // Streaming, full-scale positive
      seg_tag = "R1 R4 R6";
      repeat (720) put_sample(1'b1);
      drain("R4");
      check("R4 streamed count", got_vals.size(), 4);
      check("R1 full scale", got_vals[got_vals.size()-1], FULL);

      // Settled mode, full-scale negative
      set_mode(1'b0);
      seg_tag = "R2 R5 R6";
      repeat (720) put_sample(1'b0);
      drain("R5");
      check("R5 settled count", got_vals.size(), 6);
      check("R2 full scale", got_vals[got_vals.size()-1], -FULL);

      // Settled mode, random bitstream
      seg_tag = "R3 R5 R10";
      repeat (1080) put_sample(1'($urandom_range(0, 1)));
      drain("R3");

      // Streaming step response
      set_mode(1'b1);
      seg_tag = "R11 R6";
      repeat (480) put_sample(1'b0);
      seg_tag = "R11";
      repeat (480) put_sample(1'b1);
      drain("R11");
      check("R11 first step out inside range", int'(got_vals[got_vals.size()-4] > -FULL && got_vals[got_vals.size()-4] < FULL), 1);
      check("R11 second step out inside range", int'(got_vals[got_vals.size()-3] > -FULL && got_vals[got_vals.size()-3] < FULL), 1);
      check("R11 third step out", got_vals[got_vals.size()-2], FULL);

      seg_tag = "R3 R4";
      repeat (600) put_sample(1'($urandom_range(0, 1)));
      drain("R3");

      // Run held low: enabled samples discarded
      @(negedge clk);
      run = 1'b0;
      repeat (50) begin
         @(negedge clk);
         mod_en = 1'b1;
         bit_in = 1'($urandom_range(0, 1));
         @(negedge clk);
         mod_en = 1'b0;
      end
      drain("R9 idle");
      fast_mode = 1'b0;
      fast_m = 1'b0;
      @(negedge clk);
      run = 1'b1;
      nsamp = 0;
      seg_tag = "R9";
      repeat (360) put_sample(1'b1);
      drain("R9");
      check("R9 restart value", got_vals[got_vals.size()-1], FULL);

      check("R8 hold violations", hold_err, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule